// File: doc/BRIEF.md
# Partial-Word Transmit Packer and Receive Aligner

This block sits between a 32-bit register write port and a bit-serial flash shifter. Software queues transmit words by writing to one of four addresses; the address, not the data, says how many bytes of the word (one to four) are to be sent. Each queued word is held in a transmit FIFO together with its byte count. A serializer pops one entry at a time and shifts out that many bytes, one bit per clock. It samples the return line on the same clocks and builds a 32-bit receive word that goes into a receive FIFO. Software reads that word at a fixed address.

A short receive word is stored in the upper byte lanes of the word. The first byte received sits in the lowest of those lanes, so software can copy the bytes out in order, starting at byte offset four minus the count. A configuration write controls three things. It can hold the serializer until software gives an explicit start. It can hand the chip-select line to software. It sets the level of that line.

The serializer is a three-state machine with the states SER_IDLE, SER_SHIFT and SER_PUSH.
- In SER_IDLE it pops an entry when one is waiting and running is allowed. This is the transition SER_IDLE to SER_SHIFT.
- In SER_SHIFT it stays for eight cycles per byte. After the last bit of the last byte it takes the transition SER_SHIFT to SER_PUSH.
- In SER_PUSH it hands the assembled word to the receive FIFO for one cycle. It then returns unconditionally, SER_PUSH to SER_IDLE.

Top module: `pwq_datapath`

## Requirements
- R1: A write to address 0x1C queues an entry of 4 bytes, 0x80 one of 1 byte, 0x84 one of 2 bytes, and 0x88 one of 3 bytes. For an entry of N bytes, shift_en is high for exactly 8×N consecutive cycles. These cycles start one cycle after the entry is popped.
- R2: The bytes of an entry go out in ascending lane order: bits [7:0] first, then [15:8], and so on.
- R3: Within each byte the most significant bit appears on sdo first, one bit per shift_en cycle.
- R4: sdi is sampled on every shift_en cycle, so one byte is received for each byte sent. The receive word is pushed in the cycle after the last shift cycle.
- R5: For an entry of N bytes, the k-th received byte (k from 0) lands in byte lane 4−N+k, and the lanes below 4−N read 0. A 4-byte entry therefore keeps its received bytes in lane order.
- R6: With rd_addr = 0x20, rd_data shows the oldest receive word, and rd_en removes it. An empty receive FIFO, or any other read address, reads 0.
- R7: A 1-, 2- or 3-byte write is taken only while tx_level is 0. Otherwise it is dropped without changing tx_level and without a tx_ovf pulse.
- R8: The configuration register is written at address 0x00. With bit 15 set, no entry is popped until a write with bit 16 set. Shifting then carries on until the transmit FIFO is empty, and further entries wait for a new start. Bit 16 is never stored. With bit 15 clear, entries are popped as soon as they are present.
- R9: The transmit FIFO holds 63 entries. A 4-byte write while it is full is dropped, tx_level stays 63, and tx_ovf pulses for one cycle.
- R10: The receive FIFO holds 63 words. A push while it is full and not being read is dropped, and rx_ovf pulses for one cycle. A push in the same cycle as a read of a full FIFO is kept.
- R11: With configuration bit 14 set, cs_n equals configuration bit 10. With bit 14 clear, cs_n is low while the serializer is not in SER_IDLE, and high otherwise.
- R12: After reset both levels are 0, shift_en, tx_ovf and rx_ovf are 0, cs_n is 1 and rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe (pops the receive word at 0x20) |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 32 | Register read data |
| sdo | output | 1 | Serial data out, valid while shift_en is high |
| sdi | input | 1 | Serial data in, sampled while shift_en is high |
| shift_en | output | 1 | High for each cycle in which a bit is shifted |
| cs_n | output | 1 | Active-low flash select |
| tx_level | output | clog2(FIFO_DEPTH+1) | Transmit FIFO occupancy |
| rx_level | output | clog2(FIFO_DEPTH+1) | Receive FIFO occupancy |
| tx_ovf | output | 1 | One-cycle pulse: transmit write dropped on a full FIFO |
| rx_ovf | output | 1 | One-cycle pulse: receive word dropped on a full FIFO |

## Verification
Two events can meet in one cycle: the serializer pushing a finished receive word, and software reading the receive FIFO while it holds 63 words. The bench first fills the receive FIFO to 63 words by draining a full transmit queue. It then releases one more entry and watches shift_en. The cycle after shift_en falls is the push cycle, and the bench asserts rd_en in exactly that cycle. A correct design then shows rx_level still at 63, no rx_ovf pulse, and the oldest word on rd_data before the read. A second entry pushed without a read must then raise rx_ovf while the level stays at 63.

// File: rtl/pwq_pkg.sv
package pwq_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned LANES  = WORD_W / 8;
    localparam int unsigned CNT_W  = $clog2(LANES);

    // register addresses (byte offsets)
    localparam int OFS_CFG = 'h00;
    localparam int OFS_TX4 = 'h1C;
    localparam int OFS_RX  = 'h20;
    localparam int OFS_TX1 = 'h80;
    localparam int OFS_TX2 = 'h84;
    localparam int OFS_TX3 = 'h88;

    // configuration bit positions
    localparam int CFG_START  = 16;
    localparam int CFG_MANRUN = 15;
    localparam int CFG_MANCS  = 14;
    localparam int CFG_CSLVL  = 10;

    typedef struct packed {
        logic [CNT_W-1:0]  nm1;   // byte count minus one
        logic [WORD_W-1:0] data;
    } txent_t;

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_SHIFT,
        SER_PUSH
    } ser_state_e;
endpackage

// File: rtl/pwq_fifo.sv
module pwq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 63
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [W-1:0]                   din,
    input  logic                           pop,
    output logic [W-1:0]                   dout,
    output logic [$clog2(DEPTH+1)-1:0]     level,
    output logic                           ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign do_pop  = pop && (level != '0);
    assign do_push = push && ((level != FULL) || do_pop);
    assign dout    = (level == '0) ? '0 : mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= push && !do_push;
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end
endmodule

// File: rtl/pwq_regs.sv
module pwq_regs
    import pwq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rx_head,
    input  logic              tx_empty,
    output logic              tx_push,
    output txent_t            tx_ent,
    output logic              rx_pop,
    output logic [WORD_W-1:0] rd_data,
    output logic              run_ok,
    output logic              man_run,
    output logic              man_cs,
    output logic              cs_lvl
);
    logic tx_sel, partial, cfg_wr, start, go;

    always_comb begin
        tx_sel     = 1'b0;
        partial    = 1'b0;
        tx_ent.nm1 = '0;
        case (wr_addr)
            ADDR_W'(OFS_TX4): begin tx_sel = 1'b1; tx_ent.nm1 = CNT_W'(3); end
            ADDR_W'(OFS_TX1): begin tx_sel = 1'b1; partial = 1'b1; tx_ent.nm1 = CNT_W'(0); end
            ADDR_W'(OFS_TX2): begin tx_sel = 1'b1; partial = 1'b1; tx_ent.nm1 = CNT_W'(1); end
            ADDR_W'(OFS_TX3): begin tx_sel = 1'b1; partial = 1'b1; tx_ent.nm1 = CNT_W'(2); end
            default: ;
        endcase
    end

    assign tx_ent.data = wr_data;
    assign tx_push     = wr_en && tx_sel && (!partial || tx_empty);
    assign cfg_wr      = wr_en && (wr_addr == ADDR_W'(OFS_CFG));
    assign start       = cfg_wr && wr_data[CFG_START];
    assign run_ok      = !man_run || go;

    assign rx_pop  = rd_en && (rd_addr == ADDR_W'(OFS_RX));
    assign rd_data = (rd_addr == ADDR_W'(OFS_RX)) ? rx_head : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            man_run <= 1'b0;
            man_cs  <= 1'b0;
            cs_lvl  <= 1'b0;
            go      <= 1'b0;
        end else begin
            if (cfg_wr) begin
                man_run <= wr_data[CFG_MANRUN];
                man_cs  <= wr_data[CFG_MANCS];
                cs_lvl  <= wr_data[CFG_CSLVL];
            end
            if (start)         go <= 1'b1;
            else if (tx_empty) go <= 1'b0;
        end
    end
endmodule

// File: rtl/pwq_shifter.sv
module pwq_shifter
    import pwq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_ok,
    input  logic              tx_avail,
    input  txent_t            tx_ent,
    input  logic              sdi,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              sdo,
    output logic              shift_en,
    output logic              busy
);
    ser_state_e        st, nx;
    logic [WORD_W-1:0] txw, rxw;
    logic [7:0]        sh, rxb;
    logic [2:0]        bitc;
    logic [CNT_W-1:0]  left;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SER_IDLE;
        else        st <= nx;
    end

    // transitions
    always_comb begin
        nx = st;
        unique case (st)
            SER_IDLE:  if (tx_avail && run_ok) nx = SER_SHIFT;
            SER_SHIFT: if (bitc == 3'd7 && left == '0) nx = SER_PUSH;
            SER_PUSH:  nx = SER_IDLE;
            default:   nx = SER_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_pop   = 1'b0;
        shift_en = 1'b0;
        rx_push  = 1'b0;
        sdo      = 1'b1;
        unique case (st)
            SER_IDLE:  tx_pop = tx_avail && run_ok;
            SER_SHIFT: begin shift_en = 1'b1; sdo = sh[7]; end
            SER_PUSH:  rx_push = 1'b1;
            default: ;
        endcase
    end

    assign busy    = (st != SER_IDLE);
    assign rx_word = rxw;

    // byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txw  <= '0;
            rxw  <= '0;
            sh   <= '0;
            rxb  <= '0;
            bitc <= '0;
            left <= '0;
        end else if (tx_pop) begin
            sh   <= tx_ent.data[7:0];
            txw  <= {8'h00, tx_ent.data[WORD_W-1:8]};
            left <= tx_ent.nm1;
            bitc <= '0;
            rxw  <= '0;
        end else if (shift_en) begin
            bitc <= bitc + 1'b1;
            sh   <= {sh[6:0], 1'b0};
            rxb  <= {rxb[6:0], sdi};
            if (bitc == 3'd7) begin
                rxw  <= {rxb[6:0], sdi, rxw[WORD_W-1:8]};
                left <= left - 1'b1;
                sh   <= txw[7:0];
                txw  <= {8'h00, txw[WORD_W-1:8]};
            end
        end
    end
endmodule

// File: rtl/pwq_datapath.sv
module pwq_datapath
    import pwq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 63
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [31:0]                       wr_data,
    input  logic                              rd_en,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [31:0]                       rd_data,
    output logic                              sdo,
    input  logic                              sdi,
    output logic                              shift_en,
    output logic                              cs_n,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]   tx_level,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]   rx_level,
    output logic                              tx_ovf,
    output logic                              rx_ovf
);
    localparam int ENT_W = $bits(txent_t);

    txent_t            wr_ent, head_ent;
    logic              tx_push, tx_pop, tx_empty;
    logic              rx_push, rx_pop;
    logic [WORD_W-1:0] rx_word, rx_head;
    logic              run_ok, man_run, man_cs, cs_lvl, busy;

    assign tx_empty = (tx_level == '0);
    assign cs_n     = man_cs ? cs_lvl : !busy;

    pwq_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rx_head(rx_head),
        .tx_empty(tx_empty), .tx_push(tx_push), .tx_ent(wr_ent),
        .rx_pop(rx_pop), .rd_data(rd_data), .run_ok(run_ok),
        .man_run(man_run), .man_cs(man_cs), .cs_lvl(cs_lvl)
    );

    pwq_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .din(wr_ent), .pop(tx_pop), .dout(head_ent),
        .level(tx_level), .ovf(tx_ovf)
    );

    pwq_shifter u_ser (
        .clk(clk), .rst_n(rst_n),
        .run_ok(run_ok), .tx_avail(!tx_empty), .tx_ent(head_ent), .sdi(sdi),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .sdo(sdo), .shift_en(shift_en), .busy(busy)
    );

    pwq_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din(rx_word), .pop(rx_pop), .dout(rx_head),
        .level(rx_level), .ovf(rx_ovf)
    );
endmodule

// File: rtl/pwq_checker.sv
module pwq_checker #(
    parameter int DEPTH = 63,
    parameter int LW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          shift_en,
    input logic          cs_n,
    input logic          man_cs,
    input logic          man_run,
    input logic          run_ok,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic          tx_ovf,
    input logic          rx_ovf
);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    logic [5:0] run_len;
    logic       prev_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
            prev_sh <= 1'b0;
        end else begin
            prev_sh <= shift_en;
            if (shift_en) run_len <= prev_sh ? run_len + 1'b1 : 6'd1;
        end
    end

    // R1: every shift burst is a whole number of bytes, 1 to 4
    assert_burst_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_sh && !shift_en) |-> (run_len[2:0] == 3'd0 && run_len != 6'd0 && run_len <= 6'd32));

    // R8: while held in manual mode the transmit queue never shrinks
    assert_manual_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (man_run && !run_ok) |=> (tx_level >= $past(tx_level)));

    // R9: a transmit overflow only follows a full queue
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |-> ($past(tx_level) == FULL && tx_level == FULL));

    // R10: a receive overflow only follows a full queue
    assert_rx_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |-> ($past(rx_level) == FULL && rx_level == FULL));

    // R11: automatic select is active during every shift cycle
    assert_cs_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !man_cs) |-> !cs_n);
endmodule

bind pwq_datapath pwq_checker #(.DEPTH(FIFO_DEPTH), .LW($clog2(FIFO_DEPTH+1))) u_chk (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .cs_n(cs_n),
    .man_cs(man_cs), .man_run(man_run), .run_ok(run_ok),
    .tx_level(tx_level), .rx_level(rx_level), .tx_ovf(tx_ovf), .rx_ovf(rx_ovf)
);

// File: tb/sim_pwq_datapath.sv
module sim_pwq_datapath;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 63;

    typedef struct packed {
        logic [7:0]  a;
        logic [31:0] d;
        logic        inv;
        logic [2:0]  n;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h1C, 32'hA1B2C3D4, 1'b0, 3'd4},
        '{8'h80, 32'h0000005A, 1'b1, 3'd1},
        '{8'h84, 32'hFFFF1234, 1'b0, 3'd2},
        '{8'h88, 32'h00C0FFEE, 1'b1, 3'd3},
        '{8'h1C, 32'h80000001, 1'b1, 3'd4},
        '{8'h88, 32'h0055AA0F, 1'b0, 3'd3}
    };

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, rd_en = 0, inv = 0;
    logic [7:0]  wr_addr = 0, rd_addr = 8'h20;
    logic [31:0] wr_data = 0, rd_data;
    logic sdo, sdi, shift_en, cs_n, tx_ovf, rx_ovf;
    logic [5:0] tx_level, rx_level;

    int checks = 0, errors = 0, bitn = 0;
    bit cs_bad = 0, done = 0;
    logic [7:0] sbyte = 0;
    logic [7:0] log_b [4];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sdi = sdo ^ inv;

    pwq_datapath u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .sdo(sdo), .sdi(sdi),
        .shift_en(shift_en), .cs_n(cs_n), .tx_level(tx_level), .rx_level(rx_level),
        .tx_ovf(tx_ovf), .rx_ovf(rx_ovf)
    );

    // serial monitor
    always @(negedge clk) begin
        if (shift_en) begin
            sbyte = {sbyte[6:0], sdo};
            if (bitn[2:0] == 3'd7 && bitn < 32) log_b[bitn >> 3] = sbyte;
            bitn = bitn + 1;
            if (cs_n && !u0_cfg_mancs) cs_bad = 1;
        end
    end
    bit u0_cfg_mancs = 0;   // bench copy of what it wrote to config bit 14

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd_pop();
        @(negedge clk); rd_en = 1; rd_addr = 8'h20;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic wait_rx(input int lvl);
        for (int k = 0; k < 4000 && rx_level != 6'(lvl); k++) @(negedge clk);
    endtask

    task automatic wait_push_cycle();
        bit prev = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (prev && !shift_en) break;
            prev = shift_en;
        end
    endtask

    function automatic logic [31:0] rx_model(input logic [31:0] d, input int n, input logic iv);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r[8*(4-n+i) +: 8] = d[8*i +: 8] ^ {8{iv}};
        return r;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12: reset state
        chk(tx_level == 0 && rx_level == 0, "R12 levels", {tx_level, rx_level}, 0);
        chk(!shift_en && !tx_ovf && !rx_ovf && cs_n, "R12 outputs", {shift_en, tx_ovf, rx_ovf, cs_n}, 32'h1);
        chk(rd_data == 0, "R12/R6 empty read", rd_data, 0);

        // table walk in automatic mode
        for (int v = 0; v < 6; v++) begin
            bitn = 0;
            inv = VECS[v].inv;
            wr(VECS[v].a, VECS[v].d);
            wait_rx(1);
            repeat (2) @(negedge clk);
            chk(bitn == 8 * int'(VECS[v].n), "R1 bit count", bitn, 8 * VECS[v].n);
            for (int i = 0; i < int'(VECS[v].n); i++)
                chk(log_b[i] == VECS[v].d[8*i +: 8], "R2/R3 serial byte", log_b[i], VECS[v].d[8*i +: 8]);
            chk(rd_data == rx_model(VECS[v].d, int'(VECS[v].n), VECS[v].inv), "R4/R5 rx word",
                rd_data, rx_model(VECS[v].d, int'(VECS[v].n), VECS[v].inv));
            rd_pop();
            chk(rx_level == 0 && rd_data == 0, "R6 pop to empty", rd_data, 0);
        end
        chk(!cs_bad, "R11 auto select during shift", cs_bad, 0);
        inv = 0;

        // manual start mode
        bitn = 0;
        wr(8'h00, 32'h0000_8000);
        wr(8'h1C, 32'h0BADF00D);
        chk(tx_level == 1, "R8 queued held", tx_level, 1);
        wr(8'h80, 32'h000000AA);
        chk(tx_level == 1 && !tx_ovf, "R7 partial dropped", {tx_ovf, tx_level}, 1);
        repeat (20) @(negedge clk);
        chk(bitn == 0 && tx_level == 1, "R8 no shift before start", bitn, 0);
        wr(8'h00, 32'h0001_8000);
        wait_rx(1);
        chk(tx_level == 0 && rd_data == 32'h0BADF00D, "R8 started", rd_data, 32'h0BADF00D);
        rd_pop();
        bitn = 0;
        wr(8'h84, 32'h00004321);
        chk(tx_level == 1, "R7 partial on empty", tx_level, 1);
        repeat (20) @(negedge clk);
        chk(bitn == 0 && tx_level == 1, "R8 start self-clears", bitn, 0);
        wr(8'h00, 32'h0001_8000);
        wait_rx(1);
        chk(rd_data == 32'h43210000, "R5 two-byte align", rd_data, 32'h43210000);
        rd_pop();

        // transmit overflow
        for (int i = 0; i < DEPTH; i++) wr(8'h1C, 32'h10000000 + i);
        chk(tx_level == 6'(DEPTH), "R9 fill", tx_level, DEPTH);
        wr(8'h1C, 32'hDEADBEEF);
        chk(tx_ovf && tx_level == 6'(DEPTH), "R9 overflow pulse", {tx_ovf, tx_level}, {1'b1, 6'(DEPTH)});
        @(negedge clk);
        chk(!tx_ovf, "R9 pulse ends", tx_ovf, 0);
        wr(8'h00, 32'h0001_8000);
        wait_rx(DEPTH);
        chk(rx_level == 6'(DEPTH) && !rx_ovf, "R10 rx full", rx_level, DEPTH);

        // push and read of a full receive FIFO in the same cycle
        wr(8'h1C, 32'h77665544);
        @(negedge clk); wr_en = 1; wr_addr = 8'h00; wr_data = 32'h0001_8000;
        @(negedge clk); wr_en = 0;
        wait_push_cycle();
        chk(rd_data == 32'h10000000, "R6 oldest word", rd_data, 32'h10000000);
        rd_en = 1;
        @(negedge clk); rd_en = 0;
        chk(rx_level == 6'(DEPTH) && !rx_ovf, "R10 simultaneous push/read", {rx_ovf, rx_level}, 6'(DEPTH));
        // push into full FIFO without read
        wr(8'h1C, 32'h01020304);
        wr(8'h00, 32'h0001_8000);
        wait_push_cycle();
        @(negedge clk);
        chk(rx_ovf && rx_level == 6'(DEPTH), "R10 overflow pulse", {rx_ovf, rx_level}, {1'b1, 6'(DEPTH)});

        // manual chip select
        u0_cfg_mancs = 1;
        wr(8'h00, 32'h0000_4400);
        chk(cs_n == 1, "R11 manual high", cs_n, 1);
        wr(8'h00, 32'h0000_4000);
        chk(cs_n == 0, "R11 manual low", cs_n, 0);
        u0_cfg_mancs = 0;
        wr(8'h00, 32'h0000_0000);
        chk(cs_n == 1, "R11 auto idle", cs_n, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule